// File: doc/BRIEF.md
# Trigger Source Selector with Modulo, Gating and Prescale

This block issues the start strobe for a bank of delay counters. Two paths can produce that strobe. The internal path is a free-running divide-by-N counter clocked by the main clock. The external path takes an asynchronous trigger input and retimes it through a two-flop synchronizer. It then detects the chosen edge, blocks that edge while the gate input is low, and passes only every Nth qualified edge. A single configuration bit selects which path is live, and the path that is not selected is held idle.

The result is a registered strobe one clock wide. A 32-bit tally of issued strobes moves on the same clock edge as the strobe. The strobe is a plain control pulse and not a stream. It carries no payload, and the delay counters always accept it, so it has no valid/ready handshake and no back-pressure. All configuration pins are plain levels that are sampled every clock.

Top module: `trig_source_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `trig_o` is 0 and `trig_count_o` is 0.
- R2: In external mode, suppose an active edge of `ext_trig_i` is first sampled at clock edge k. Then `trig_o` is high for exactly the one cycle that follows edge k+2.
- R3: When `cfg_falling_i` is 0, only low-to-high transitions of `ext_trig_i` are active edges. When it is 1, only high-to-low transitions are active. A transition in the other direction never produces a strobe.
- R4: An active edge detected while `ext_gate_i` is 0 produces no strobe and does not advance the prescaler.
- R5: With `cfg_prescale_i` equal to P (P ≥ 2), only the Pth, 2Pth, ... qualified edges after a prescaler restart produce a strobe. A value of 0 or 1 passes every qualified edge.
- R6: In internal mode with `cfg_modulus_i` equal to N (a value of 0 behaves as 1), the first strobe is registered at the Nth clock edge after the edge that first samples the new setting. Later strobes follow every N clocks.
- R7: A ratio counter restarts from zero when its ratio value changes, and also when its path becomes selected. A strobe that was due is dropped on the restart edge.
- R8: Only the selected path can produce strobes. External edges have no effect in internal mode, and the internal counter issues nothing in external mode.
- R9: `trig_count_o` increases by exactly one on every clock edge at which `trig_o` is registered high. It never changes otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| ext_gate_i | input | 1 | External edge enable (1 = pass) |
| cfg_use_ext_i | input | 1 | Source select: 1 = external path, 0 = internal counter |
| cfg_modulus_i | input | 32 | Internal divide ratio N |
| cfg_prescale_i | input | 16 | External prescale ratio P |
| cfg_falling_i | input | 1 | Active edge: 0 = rising, 1 = falling |
| trig_o | output | 1 | One-cycle start strobe |
| trig_count_o | output | 32 | Running count of issued strobes |

## Verification
The assertions assume that `ext_gate_i` and the configuration pins are synchronous to `clk`. They also assume that `ext_trig_i` is low when reset is released, so the synchronizer does not see a false edge. The stimulus drives every input at the falling clock edge. It holds each trigger level for at least five cycles, so that successive edges are never adjacent at the edge detector. It changes gate, polarity, ratio or source only while the trigger input is steady, and then leaves several cycles before the next edge so that every restart has settled.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } trig_src_e;
endpackage

// File: rtl/tsg_sync_edge.sv
// Retimes an asynchronous level and flags one selected transition per change.
module tsg_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic falling_i,
  output logic edge_o
);
  localparam int TAP_W = SYNC_STAGES + 1;

  logic [TAP_W-1:0] taps_q;
  logic             cur_lvl;
  logic             prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= {taps_q[TAP_W-2:0], async_i};
  end

  assign cur_lvl  = taps_q[SYNC_STAGES-1];
  assign prev_lvl = taps_q[SYNC_STAGES];
  // A transition whose new level is the one the polarity asks for.
  assign edge_o   = (cur_lvl ^ prev_lvl) & (cur_lvl ^ falling_i);

  // R2: a detected edge lasts one cycle only
  p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tsg_ratio_counter.sv
// Counts events and ticks on every Nth one; ratio 0 acts as 1.
module tsg_ratio_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  input  logic         event_i,
  output logic         tick_o
);
  logic [W-1:0] ratio_q;
  logic         en_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;
  logic         restart;

  assign last    = (ratio_i == '0) ? '0 : ratio_i - 1'b1;
  assign restart = en_i & ((ratio_i != ratio_q) | !en_q);
  assign tick_o  = en_i & !restart & event_i & (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      en_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      ratio_q <= ratio_i;
      en_q    <= en_i;
      if (!en_i || restart)      cnt_q <= '0;
      else if (event_i)          cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: the position never passes the last slot of a steady ratio
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart) |-> (cnt_q <= last));
  // R7: a restart leaves the counter at zero
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/trig_source_gen.sv
module trig_source_gen #(
  parameter int MOD_W    = 32,
  parameter int PRE_W    = 16,
  parameter int TCOUNT_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_trig_i,
  input  logic                ext_gate_i,
  input  logic                cfg_use_ext_i,
  input  logic [MOD_W-1:0]    cfg_modulus_i,
  input  logic [PRE_W-1:0]    cfg_prescale_i,
  input  logic                cfg_falling_i,
  output logic                trig_o,
  output logic [TCOUNT_W-1:0] trig_count_o
);
  import tsg_pkg::*;

  trig_src_e src_sel;
  logic      ext_edge;
  logic      ext_qual;
  logic      ext_tick;
  logic      int_tick;
  logic      next_trig;

  assign src_sel = cfg_use_ext_i ? SRC_EXTERNAL : SRC_INTERNAL;

  tsg_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_i   (ext_trig_i),
    .falling_i (cfg_falling_i),
    .edge_o    (ext_edge)
  );

  assign ext_qual = ext_edge & ext_gate_i;

  tsg_ratio_counter #(.W(PRE_W)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (src_sel == SRC_EXTERNAL),
    .ratio_i (cfg_prescale_i),
    .event_i (ext_qual),
    .tick_o  (ext_tick)
  );

  tsg_ratio_counter #(.W(MOD_W)) u_modulo (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (src_sel == SRC_INTERNAL),
    .ratio_i (cfg_modulus_i),
    .event_i (1'b1),
    .tick_o  (int_tick)
  );

  assign next_trig = ext_tick | int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_o       <= 1'b0;
      trig_count_o <= '0;
    end else begin
      trig_o       <= next_trig;
      trig_count_o <= trig_count_o + TCOUNT_W'(next_trig);
    end
  end

  // R9: tally moves by exactly the strobe
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (trig_count_o == $past(trig_count_o) + TCOUNT_W'(trig_o)));
  // R2: external strobes are never back to back
  p_ext_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_use_ext_i && $past(cfg_use_ext_i) && $past(cfg_use_ext_i, 2) && trig_o)
      |-> !$past(trig_o));
  // R4: a closed gate in external mode yields no strobe
  p_gate_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_use_ext_i) && !$past(ext_gate_i)) |-> !trig_o);
endmodule

// File: tb/test_trig_source_gen.sv
module test_trig_source_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext = 1'b0;
  logic        gate = 1'b1;
  logic        use_ext = 1'b1;
  logic        falling = 1'b0;
  logic [31:0] modulus = 32'd1;
  logic [15:0] prescale = 16'd1;
  logic        trig;
  logic [31:0] tcount;

  always #5 clk = ~clk;

  trig_source_gen i_trig_source_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_trig_i     (ext),
    .ext_gate_i     (gate),
    .cfg_use_ext_i  (use_ext),
    .cfg_modulus_i  (modulus),
    .cfg_prescale_i (prescale),
    .cfg_falling_i  (falling),
    .trig_o         (trig),
    .trig_count_o   (tcount)
  );

  int    cyc = 0;
  int    exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  int    expected_total = 0;
  int    pre_cnt = 0;
  int    seg_end = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int t, string tag);
    exp_q.push_back(t);
    tag_q.push_back(tag);
    expected_total++;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        check(1'b0, tag_q[0], "missed strobe at cycle", -1, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (trig) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          check(1'b1, tag_q[0], "strobe", cyc, cyc);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end else begin
          check(1'b0, "R8", "unexpected strobe at cycle", cyc,
                (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
    end
  end

  task automatic ext_to(logic lvl);
    bit qual;
    int ratio;
    @(negedge clk);
    qual  = (lvl != ext) && (lvl == !falling) && gate && use_ext;
    ratio = (prescale == 0) ? 1 : int'(prescale);
    ext   = lvl;
    if (qual) begin
      pre_cnt++;
      if (pre_cnt >= ratio) begin
        pre_cnt = 0;
        push(cyc + 3, (ratio > 1) ? "R5" : "R2");
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pre(logic [15:0] v);
    @(negedge clk);
    if (v != prescale) pre_cnt = 0;
    prescale = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic int_start(int n, int len, string tag);
    int ne;
    int c;
    @(negedge clk);
    use_ext = 1'b0;
    modulus = n;
    c  = cyc;
    ne = (n == 0) ? 1 : n;
    for (int t = c + ne + 1; t <= c + len; t += ne) push(t, tag);
    seg_end = c + len;
  endtask

  task automatic wait_seg();
    while (cyc < seg_end - 1) @(negedge clk);
  endtask

  task automatic int_end();
    @(negedge clk);
    use_ext = 1'b1;
    pre_cnt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_check(string tag);
    repeat (6) @(negedge clk);
    check(tcount == expected_total, tag, "strobe tally", tcount, expected_total);
    check(exp_q.size() == 0, tag, "pending expected strobes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(trig == 1'b0, "R1", "trig_o in reset", trig, 0);
    check(tcount == 0, "R1", "tally in reset", tcount, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig == 1'b0, "R1", "trig_o after release", trig, 0);
    check(tcount == 0, "R1", "tally after release", tcount, 0);
    repeat (3) @(negedge clk);

    // R2 / R3: rising polarity, falling edge ignored
    ext_to(1'b1); ext_to(1'b0); ext_to(1'b1); ext_to(1'b0);
    count_check("R9");

    // R4: gated edges produce nothing
    @(negedge clk); gate = 1'b0;
    ext_to(1'b1); ext_to(1'b0);
    @(negedge clk); gate = 1'b1;
    count_check("R4");

    // R3: falling polarity
    @(negedge clk); falling = 1'b1;
    repeat (3) @(negedge clk);
    ext_to(1'b1); ext_to(1'b0); ext_to(1'b1); ext_to(1'b0);
    @(negedge clk); falling = 1'b0;
    repeat (3) @(negedge clk);
    count_check("R3");

    // R5: prescale by 3 over seven edges
    set_pre(16'd3);
    for (int i = 0; i < 7; i++) begin ext_to(1'b1); ext_to(1'b0); end
    // R7: ratio change drops the pending count
    set_pre(16'd2);
    ext_to(1'b1); ext_to(1'b0); ext_to(1'b1); ext_to(1'b0);
    // R4: gated edge does not advance prescaler
    ext_to(1'b1); ext_to(1'b0);
    @(negedge clk); gate = 1'b0;
    ext_to(1'b1); ext_to(1'b0);
    @(negedge clk); gate = 1'b1;
    ext_to(1'b1); ext_to(1'b0);
    // R5: ratio 0 passes every edge
    set_pre(16'd0);
    ext_to(1'b1); ext_to(1'b0); ext_to(1'b1); ext_to(1'b0);
    count_check("R5");

    // R6: internal divide by 5, then R7 change to 3
    int_start(5, 23, "R6"); wait_seg();
    int_start(3, 14, "R7"); wait_seg();
    int_end();
    int_start(1, 6, "R6"); wait_seg();
    int_end();
    int_start(0, 4, "R6"); wait_seg();
    int_end();
    count_check("R6");

    // R8: external edges ignored while internal path runs
    int_start(40, 60, "R8");
    ext_to(1'b1); ext_to(1'b0); ext_to(1'b1); ext_to(1'b0);
    wait_seg();
    int_end();
    // R8: no internal strobes in external mode
    repeat (30) @(negedge clk);
    count_check("R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule